// File: doc/BRIEF.md
# Bitwise Logic Unit With Flags

This block carries out the four bitwise operations of an execution stage: AND, OR and XOR combine a destination operand with a source operand, and NOT inverts the destination. The result is the value the destination takes next. The width of the data is a parameter. The block has no clock and no state, so the result and the status come out in the same cycle as the operands. Instruction decode, memory access and the choice between a register and an immediate source all sit in the surrounding datapath.

Along with the result the unit drives a five-bit status vector. The two-operand operations clear carry and overflow and take sign, zero and parity from the result. NOT leaves the status alone: it copies the previous status, supplied on an input, straight to the output.

Top module: `blu_unit`

## Requirements
- R1: With op_code 2'b00 the result equals dst_val AND src_val.
- R2: With op_code 2'b01 the result equals dst_val OR src_val.
- R3: With op_code 2'b10 the result equals dst_val XOR src_val.
- R4: With op_code 2'b11 the result equals the bitwise inverse of dst_val, whatever value src_val holds.
- R5: For op_code 2'b00, 2'b01 and 2'b10, carry (flags_next bit 4) and overflow (flags_next bit 3) are 0.
- R6: For the two-operand operations, sign (flags_next bit 2) equals the most significant bit of the result.
- R7: For the two-operand operations, zero (flags_next bit 1) is 1 exactly when every result bit is 0.
- R8: For the two-operand operations, parity (flags_next bit 0) is 1 exactly when the lowest eight bits of the result hold an even number of ones. If the data is narrower than eight bits, all of its bits count.
- R9: With op_code 2'b11, flags_next equals flags_prev in every bit.
- R10: The outputs follow any change of the inputs in the same cycle, with no clock edge in between.
- R11: Start from 16'h0055, then apply AND 1Fh, OR C0h, XOR 0Fh and NOT in turn, each step feeding its result back as the destination. The low byte of the result must then read 15h, D5h, DAh and 25h, in that order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 2 | Operation select: 00 AND, 01 OR, 10 XOR, 11 NOT |
| dst_val | input | WIDTH | Destination operand |
| src_val | input | WIDTH | Source operand; NOT does not use it |
| flags_prev | input | 5 | Status before the operation, as {carry, overflow, sign, zero, parity} |
| result | output | WIDTH | New destination value |
| flags_next | output | 5 | Status after the operation, same bit order as flags_prev |

## Verification
Zero and parity come from separate parts of the result, and both rise together on an all-zero result, since zero ones is an even count. The bench forces that case with an AND of complementary operands and with an XOR of equal operands. It then checks both bits against its own bit count, so neither bit can be hiding the other. It also provokes sign and parity together on results with the top bit set and an even low byte. For NOT it feeds in an unusual previous status, which must come through untouched even when the inverted result would set different flags.

// File: rtl/blu_pkg.sv
package blu_pkg;

  typedef enum logic [1:0] {
    OP_AND = 2'd0,
    OP_OR  = 2'd1,
    OP_XOR = 2'd2,
    OP_NOT = 2'd3
  } blu_op_e;

  localparam int FLAG_W   = 5;
  localparam int FL_CARRY = 4;
  localparam int FL_OVFL  = 3;
  localparam int FL_SIGN  = 2;
  localparam int FL_ZERO  = 1;
  localparam int FL_PAR   = 0;
  localparam int PAR_SPAN = 8;

  // Even number of ones in an eight-bit slice gives 1
  function automatic logic even_ones8(input logic [PAR_SPAN-1:0] b);
    return ~(^b);
  endfunction

endpackage

// File: rtl/blu_logic_core.sv
module blu_logic_core
  import blu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  blu_op_e          op,
  input  logic [WIDTH-1:0] dst,
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] res,
  output logic             is_not
);

  assign is_not = (op == OP_NOT);

  always_comb begin
    unique case (op)
      OP_AND:  res = dst & src;
      OP_OR:   res = dst | src;
      OP_XOR:  res = dst ^ src;
      default: res = ~dst;
    endcase
  end

  // The NOT path must not depend on the source operand
  always_comb begin
    if (is_not) begin
      AST_NOT_SRC_FREE: assert ((res ^ dst) == {WIDTH{1'b1}}); // R4
    end
  end

endmodule

// File: rtl/blu_flag_gen.sv
module blu_flag_gen
  import blu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]  res,
  input  logic              keep_prev,
  input  logic [FLAG_W-1:0] flags_prev,
  output logic [FLAG_W-1:0] flags
);

  localparam int PW = (WIDTH < PAR_SPAN) ? WIDTH : PAR_SPAN;

  logic [PAR_SPAN-1:0] par_slice;
  logic                res_is_zero;
  logic                res_even;
  logic [FLAG_W-1:0]   fresh;

  generate
    if (WIDTH < PAR_SPAN) begin : g_pad
      assign par_slice = {{(PAR_SPAN-PW){1'b0}}, res[PW-1:0]};
    end else begin : g_slice
      assign par_slice = res[PAR_SPAN-1:0];
    end
  endgenerate

  assign res_is_zero = ~(|res);
  assign res_even    = even_ones8(par_slice);

  always_comb begin
    fresh           = '0;
    fresh[FL_SIGN]  = res[WIDTH-1];
    fresh[FL_ZERO]  = res_is_zero;
    fresh[FL_PAR]   = res_even;
  end

  assign flags = keep_prev ? flags_prev : fresh;

  always_comb begin
    if (!keep_prev) begin
      AST_NO_OVERFLOW: assert (flags[FL_CARRY] == 1'b0 && flags[FL_OVFL] == 1'b0); // R5
      AST_SIGN_IS_MSB: assert (flags[FL_SIGN] == res[WIDTH-1]); // R6
      AST_ZERO_EXACT:  assert (flags[FL_ZERO] == (res == '0)); // R7
    end
  end

endmodule

// File: rtl/blu_unit.sv
module blu_unit
  import blu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [1:0]       op_code,
  input  logic [WIDTH-1:0] dst_val,
  input  logic [WIDTH-1:0] src_val,
  input  logic [4:0]       flags_prev,
  output logic [WIDTH-1:0] result,
  output logic [4:0]       flags_next
);

  blu_op_e          op_sel;
  logic [WIDTH-1:0] core_res;
  logic             is_not_op;

  assign op_sel = blu_op_e'(op_code);

  blu_logic_core #(.WIDTH(WIDTH)) u_core (
    .op     (op_sel),
    .dst    (dst_val),
    .src    (src_val),
    .res    (core_res),
    .is_not (is_not_op)
  );

  blu_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .res        (core_res),
    .keep_prev  (is_not_op),
    .flags_prev (flags_prev),
    .flags      (flags_next)
  );

  assign result = core_res;

  always_comb begin
    if (op_code == 2'b11) begin
      AST_NOT_FLAGS_HOLD: assert (flags_next == flags_prev); // R9
    end
  end

endmodule

// File: tb/blu_unit_test.sv
module blu_unit_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   op_code;
  logic [W-1:0] dst_val, src_val, result;
  logic [4:0]   flags_prev, flags_next;
  int           vectors = 0;
  int           miscompares = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  blu_unit #(.WIDTH(W)) uut (
    .op_code(op_code), .dst_val(dst_val), .src_val(src_val),
    .flags_prev(flags_prev), .result(result), .flags_next(flags_next)
  );

  function automatic logic [W-1:0] ref_res(input logic [1:0] o, input logic [W-1:0] d, input logic [W-1:0] s);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      case (o)
        2'b00: r[i] = d[i] && s[i];
        2'b01: r[i] = d[i] || s[i];
        2'b10: r[i] = d[i] != s[i];
        default: r[i] = !d[i];
      endcase
    end
    return r;
  endfunction

  function automatic logic [4:0] ref_flags(input logic [1:0] o, input logic [W-1:0] r, input logic [4:0] fp);
    int ones = 0;
    if (o == 2'b11) return fp;
    for (int i = 0; i < 8; i++) if (r[i]) ones++;
    return {1'b0, 1'b0, r[W-1], (r == 0), (ones % 2 == 0)};
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got_r, input logic [W-1:0] exp_r,
                       input logic [4:0] got_f, input logic [4:0] exp_f);
    vectors++;
    if (got_r !== exp_r || got_f !== exp_f) begin
      miscompares++;
      $display("FAIL %s: result %h flags %b, expected result %h flags %b", tag, got_r, got_f, exp_r, exp_f);
    end
  endtask

  task automatic apply(input string tag, input logic [1:0] o, input logic [W-1:0] d,
                       input logic [W-1:0] s, input logic [4:0] fp);
    @(negedge clk);
    op_code = o; dst_val = d; src_val = s; flags_prev = fp;
    #1;
    check(tag, result, ref_res(o, d, s), flags_next, ref_flags(o, ref_res(o, d, s), fp));
  endtask

  task automatic t_idle;
    // all-zero AND after reset: zero and parity both set
    check("R7 R8 idle", result, 16'h0000, flags_next, 5'b00011);
  endtask

  task automatic t_and;
    apply("R1 R5", 2'b00, 16'hF0F0, 16'h3C3C, 5'b11000);
    apply("R1 R7 R8 zero+parity", 2'b00, 16'hA5A5, 16'h5A5A, 5'b11111);
    apply("R1 R6 sign+parity", 2'b00, 16'hFFFF, 16'h8003, 5'b00000);
  endtask

  task automatic t_or;
    apply("R2 R5", 2'b01, 16'h1200, 16'h0034, 5'b11000);
    apply("R2 R8 odd low byte", 2'b01, 16'h0001, 16'h0006, 5'b00001);
  endtask

  task automatic t_xor;
    apply("R3 R7 equal operands", 2'b10, 16'hBEEF, 16'hBEEF, 5'b11100);
    apply("R3 R6", 2'b10, 16'h7FFF, 16'hFFFF, 5'b00000);
  endtask

  task automatic t_not;
    apply("R4 R9", 2'b11, 16'h00FF, 16'h1234, 5'b10101);
    apply("R4 source ignored", 2'b11, 16'h00FF, 16'hFFFF, 5'b01010);
    apply("R9 zero result keeps prev", 2'b11, 16'hFFFF, 16'h0000, 5'b11000);
  endtask

  task automatic t_same_cycle;
    // R10: output changes without a clock edge
    op_code = 2'b01; dst_val = 16'h0F00; src_val = 16'h00F0; flags_prev = 5'b0;
    #1;
    check("R10 first", result, 16'h0FF0, flags_next, ref_flags(2'b01, 16'h0FF0, 5'b0));
    src_val = 16'h000F;
    #1;
    check("R10 second", result, 16'h0F0F, flags_next, ref_flags(2'b01, 16'h0F0F, 5'b0));
  endtask

  task automatic t_sequence;
    logic [W-1:0] acc = 16'h0055;
    logic [7:0] want [4] = '{8'h15, 8'hD5, 8'hDA, 8'h25};
    logic [1:0] ops  [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
    logic [7:0] imms [4] = '{8'h1F, 8'hC0, 8'h0F, 8'h00};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      op_code = ops[k]; dst_val = acc; src_val = {8'h00, imms[k]}; flags_prev = 5'b0;
      #1;
      vectors++;
      if (result[7:0] !== want[k]) begin
        miscompares++;
        $display("FAIL R11 step %0d: low byte %h, expected %h", k, result[7:0], want[k]);
      end
      acc = result;
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    op_code = 2'b00; dst_val = '0; src_val = '0; flags_prev = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_idle();
    t_and();
    t_or();
    t_xor();
    t_not();
    t_same_cycle();
    t_sequence();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule